// File: doc/BRIEF.md
# Four-Channel PWM Control Register Front End

This block is the register-side front end of a four-channel pulse-width modulator. Software talks to it over a simple synchronous bus with an address, write data, a write strobe, a read strobe and registered read data. It turns those accesses into steady control outputs for the channel cores: a run bit per channel, a prescale code, an output-invert bit, and the active duty and period counts. Each core returns a one-cycle pulse when it begins a new period. The front end gathers those pulses into a flag register that clears when read.

Channels are started and stopped through two separate set-only words, so several channels can change in one write without touching the rest. A status word shows which channels are running. Each channel has a 32-byte window that holds a mode word, the duty and period counts, and a staging word. A value written to the staging word waits in that channel and is copied into either the duty count or the period count at that channel's next period start. Software picks the target in the mode word beforehand. This lets the output change on a period boundary without a glitch. Waveform generation itself happens in the channel cores.

Top module: `pwm_regif`

## Requirements
- R1: A write to byte address 0x004 sets run bit n for every data bit n that is 1. Zero bits leave their run bits unchanged. Run bit n is output as `ch_run[n]`.
- R2: A write to byte address 0x008 clears run bit n for every data bit n that is 1. Zero bits leave their run bits unchanged.
- R3: A read of 0x00C returns the run vector in data bits [3:0] and zero in all higher bits. With every channel running it reads 0x0000000F.
- R4: A period-start pulse on `ch_period_start[n]` sets flag bit n. The flag stays set until it is cleared by a read.
- R5: A read of 0x01C returns the flag vector in bits [3:0], with zeros above, and clears every flag in the same access.
- R6: A period-start pulse that arrives in the same cycle as a read of 0x01C does not appear in that read's data. It is still present in the flags afterwards.
- R7: Channel n's window starts at 0x200 + n*0x20. Inside the window the mode word is at offset 0x00, the duty count at 0x04, the period count at 0x08 and the staging word at 0x10. An access to one channel leaves every other channel unchanged.
- R8: Mode word layout: prescale in bits [3:0], invert in bit 9, staging target in bit 10 (0 = duty, 1 = period). These fields read back exactly as written, and all other bits read 0. Prescale and invert drive `ch_prescale` and `ch_invert`.
- R9: A write to the staging word holds that value, and the staging word reads it back. At that channel's next period start the held value is copied into the duty count or the period count, as chosen by mode bit 10. Period starts on other channels do not trigger the copy.
- R10: The duty and period words read back the active counts, which are the values driven on `ch_duty` and `ch_period`. A staged value does not appear there before its copy. A direct write to either word takes effect in the next cycle. Both counts are 16 bits wide and the upper bits read 0.
- R11: A read of any address that is not mapped returns 0, and a write to such an address changes nothing. This covers global offsets other than the four listed above, window offsets other than the four listed, addresses beyond the last channel, and addresses that are not word aligned.
- R12: Read data appears on `bus_rdata` in the cycle after the read strobe. It is 0 in any cycle that follows a cycle without a read strobe.
- R13: After reset every run bit, flag, mode field, count and staging word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| ch_period_start | input | 4 | One-cycle period-start pulse from each channel core |
| ch_run | output | 4 | Run control per channel |
| ch_prescale | output | 16 | Prescale code, 4 bits per channel |
| ch_invert | output | 4 | Output invert per channel |
| ch_duty | output | 64 | Active duty count, 16 bits per channel |
| ch_period | output | 64 | Active period count, 16 bits per channel |

## Verification
Two events can fall in the same cycle: the read that clears the flag word and a period-start pulse from a channel core. The second collision is a staging copy on one channel alongside period starts on another. The bench creates the first by raising the read strobe and a pulse at the same falling edge while a different flag is already set. It expects the read to return only the old flag and a second read to return only the new one. For the staging copy it checks the active counts on the ports and in readback before and after each pulse, including pulses on a channel other than the one that holds the staged value.

// File: rtl/pwm_regif_pkg.sv
package pwm_regif_pkg;
    // Global word offsets
    localparam logic [11:0] OFF_START  = 12'h004;
    localparam logic [11:0] OFF_STOP   = 12'h008;
    localparam logic [11:0] OFF_STATUS = 12'h00C;
    localparam logic [11:0] OFF_FLAGS  = 12'h01C;
    // Channel window geometry
    localparam logic [11:0] WIN_BASE   = 12'h200;
    localparam int          WIN_SHIFT  = 5;
    // Offsets inside a window
    localparam logic [4:0]  WOFF_MODE  = 5'h00;
    localparam logic [4:0]  WOFF_DUTY  = 5'h04;
    localparam logic [4:0]  WOFF_PER   = 5'h08;
    localparam logic [4:0]  WOFF_STAGE = 5'h10;
    // Mode word bit positions
    localparam int          MB_INV     = 9;
    localparam int          MB_TGT     = 10;

    typedef struct packed {
        logic       tgt_period;
        logic       invert;
        logic [3:0] prescale;
    } mode_t;

    typedef struct packed {
        logic mode;
        logic duty;
        logic per;
        logic stage;
    } wsel_t;
endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_regif_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_start,
    output logic              hit_stop,
    output logic              hit_status,
    output logic              hit_flags,
    output logic [NCH-1:0]    win_hit,
    output wsel_t             wsel
);
    localparam logic [ADDR_W-1:0] WIN_END =
        ADDR_W'(WIN_BASE) + ADDR_W'(NCH << WIN_SHIFT);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] idx;
    logic              in_win;

    always_comb begin
        hit_start  = (addr == ADDR_W'(OFF_START));
        hit_stop   = (addr == ADDR_W'(OFF_STOP));
        hit_status = (addr == ADDR_W'(OFF_STATUS));
        hit_flags  = (addr == ADDR_W'(OFF_FLAGS));
        rel        = addr - ADDR_W'(WIN_BASE);
        idx        = rel >> WIN_SHIFT;
        in_win     = (addr >= ADDR_W'(WIN_BASE)) && (addr < WIN_END);
        wsel.mode  = in_win && (rel[4:0] == WOFF_MODE);
        wsel.duty  = in_win && (rel[4:0] == WOFF_DUTY);
        wsel.per   = in_win && (rel[4:0] == WOFF_PER);
        wsel.stage = in_win && (rel[4:0] == WOFF_STAGE);
        for (int i = 0; i < NCH; i++) begin
            win_hit[i] = in_win && (idx == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/pwm_glob_ctrl.sv
module pwm_glob_ctrl #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           do_start,
    input  logic           do_stop,
    input  logic           do_flag_rd,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] period_start,
    output logic [NCH-1:0] run,
    output logic [NCH-1:0] flags
);
    typedef struct packed {
        logic [NCH-1:0] run;
        logic [NCH-1:0] flags;
    } glob_t;

    glob_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (do_start) st_d.run = st_q.run | mask;
        if (do_stop)  st_d.run = st_q.run & ~mask;
        // clear on read, but a pulse in the same cycle survives
        st_d.flags = (do_flag_rd ? '0 : st_q.flags) | period_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run   = st_q.run;
    assign flags = st_q.flags;
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_regif_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wsel_t         wr,
    input  mode_t         mode_in,
    input  logic [DW-1:0] val_in,
    input  logic          period_start,
    output mode_t         mode,
    output logic [DW-1:0] duty,
    output logic [DW-1:0] period,
    output logic [DW-1:0] staged
);
    typedef struct packed {
        mode_t         mode;
        logic [DW-1:0] duty;
        logic [DW-1:0] period;
        logic [DW-1:0] staged;
        logic          pend;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_start && st_q.pend) begin
            if (st_q.mode.tgt_period) st_d.period = st_q.staged;
            else                      st_d.duty   = st_q.staged;
            st_d.pend = 1'b0;
        end
        if (wr.mode) st_d.mode = mode_in;
        if (wr.duty) st_d.duty = val_in;
        if (wr.per)  st_d.period = val_in;
        if (wr.stage) begin
            st_d.staged = val_in;
            st_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode   = st_q.mode;
    assign duty   = st_q.duty;
    assign period = st_q.period;
    assign staged = st_q.staged;
endmodule

// File: rtl/pwm_regif.sv
module pwm_regif
    import pwm_regif_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    ch_period_start,
    output logic [NCH-1:0]    ch_run,
    output logic [NCH*4-1:0]  ch_prescale,
    output logic [NCH-1:0]    ch_invert,
    output logic [NCH*DW-1:0] ch_duty,
    output logic [NCH*DW-1:0] ch_period
);
    logic           hit_start, hit_stop, hit_status, hit_flags;
    logic [NCH-1:0] win_hit;
    wsel_t          wsel;
    logic [NCH-1:0] isr_vec;
    mode_t          mode_in;
    mode_t          modes  [NCH];
    logic [DW-1:0]  stages [NCH];

    pwm_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr       (bus_addr),
        .hit_start  (hit_start),
        .hit_stop   (hit_stop),
        .hit_status (hit_status),
        .hit_flags  (hit_flags),
        .win_hit    (win_hit),
        .wsel       (wsel)
    );

    pwm_glob_ctrl #(.NCH(NCH)) u_glob (
        .clk          (clk),
        .rst_n        (rst_n),
        .do_start     (bus_wr && hit_start),
        .do_stop      (bus_wr && hit_stop),
        .do_flag_rd   (bus_rd && hit_flags),
        .mask         (bus_wdata[NCH-1:0]),
        .period_start (ch_period_start),
        .run          (ch_run),
        .flags        (isr_vec)
    );

    assign mode_in.tgt_period = bus_wdata[MB_TGT];
    assign mode_in.invert     = bus_wdata[MB_INV];
    assign mode_in.prescale   = bus_wdata[3:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        wsel_t wr_g;
        assign wr_g = bus_wr && win_hit[g] ? wsel : '0;
        pwm_chan_regs #(.DW(DW)) u_regs (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr           (wr_g),
            .mode_in      (mode_in),
            .val_in       (bus_wdata[DW-1:0]),
            .period_start (ch_period_start[g]),
            .mode         (modes[g]),
            .duty         (ch_duty[g*DW +: DW]),
            .period       (ch_period[g*DW +: DW]),
            .staged       (stages[g])
        );
        assign ch_prescale[g*4 +: 4] = modes[g].prescale;
        assign ch_invert[g]          = modes[g].invert;
    end

    if (DW < DATA_W) begin : g_sink
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DW];
    end

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t           rd_d, rd_q;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (hit_status) rd_val = DATA_W'(ch_run);
        if (hit_flags)  rd_val = DATA_W'(isr_vec);
        for (int i = 0; i < NCH; i++) begin
            if (win_hit[i]) begin
                if (wsel.mode) begin
                    rd_val[3:0]    = modes[i].prescale;
                    rd_val[MB_INV] = modes[i].invert;
                    rd_val[MB_TGT] = modes[i].tgt_period;
                end
                if (wsel.duty)  rd_val = DATA_W'(ch_duty[i*DW +: DW]);
                if (wsel.per)   rd_val = DATA_W'(ch_period[i*DW +: DW]);
                if (wsel.stage) rd_val = DATA_W'(stages[i]);
            end
        end
        rd_d.rdata = bus_rd ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
endmodule

// File: rtl/pwm_regif_chk.sv
module pwm_regif_chk
    import pwm_regif_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCH-1:0]    wmask,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NCH-1:0]    ch_period_start,
    input logic [NCH-1:0]    ch_run,
    input logic [NCH-1:0]    isr_vec
);
    logic wr_start, wr_stop, rd_status, rd_flags;
    assign wr_start  = bus_wr && bus_addr == ADDR_W'(OFF_START);
    assign wr_stop   = bus_wr && bus_addr == ADDR_W'(OFF_STOP);
    assign rd_status = bus_rd && bus_addr == ADDR_W'(OFF_STATUS);
    assign rd_flags  = bus_rd && bus_addr == ADDR_W'(OFF_FLAGS);

    p_start_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (ch_run & $past(wmask)) == $past(wmask));

    p_run_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_start || wr_stop) |=> $stable(ch_run));

    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> (ch_run & $past(wmask)) == '0);

    p_status_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> bus_rdata == DATA_W'($past(ch_run)));

    p_flag_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |ch_period_start |=> (isr_vec & $past(ch_period_start)) == $past(ch_period_start));

    p_flag_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags |=> bus_rdata == DATA_W'($past(isr_vec)));

    p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flags |=> isr_vec == $past(ch_period_start));

    p_idle_rdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
endmodule

bind pwm_regif pwm_regif_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .wmask           (bus_wdata[NCH-1:0]),
    .bus_wr          (bus_wr),
    .bus_rd          (bus_rd),
    .bus_rdata       (bus_rdata),
    .ch_period_start (ch_period_start),
    .ch_run          (ch_run),
    .isr_vec         (isr_vec)
);

// File: tb/sim_pwm_regif.sv
`timescale 1ns/1ps
module sim_pwm_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  ch_period_start = '0;
    logic [3:0]  ch_run;
    logic [15:0] ch_prescale;
    logic [3:0]  ch_invert;
    logic [63:0] ch_duty;
    logic [63:0] ch_period;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_regif u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ch_period_start(ch_period_start), .ch_run(ch_run),
        .ch_prescale(ch_prescale), .ch_invert(ch_invert),
        .ch_duty(ch_duty), .ch_period(ch_period)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] ps, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; ch_period_start = ps;
        @(negedge clk);
        bus_rd = 1'b0; ch_period_start = '0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        ch_period_start = m;
        @(negedge clk);
        ch_period_start = '0;
    endtask

    function automatic logic [11:0] wa(input int ch, input int off);
        return 12'(12'h200 + ch * 32 + off);
    endfunction

    function automatic logic [31:0] pat(input int ch, input int off);
        return 32'h5A5A_F00F + 32'(ch) * 32'h0101_1111 + 32'(off) * 32'h0000_0037;
    endfunction

    function automatic logic [31:0] rmask(input int off);
        case (off)
            0:          return 32'h0000_060F;
            4, 8, 16:   return 32'h0000_FFFF;
            default:    return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        chk("R13 run", 64'(ch_run), 64'h0);
        chk("R13 duty", ch_duty, 64'h0);
        chk("R13 period", ch_period, 64'h0);
        chk("R13 prescale", 64'(ch_prescale), 64'h0);
        rd(12'h00C, 4'h0, d); chk("R13 status", 64'(d), 64'h0);
        rd(12'h01C, 4'h0, d); chk("R13 flags", 64'(d), 64'h0);
        for (int c = 0; c < 4; c++) begin
            rd(wa(c, 0), 4'h0, d); chk("R13 mode", 64'(d), 64'h0);
            rd(wa(c, 16), 4'h0, d); chk("R13 stage", 64'(d), 64'h0);
        end

        // R1 R2 R3 start/stop sweep
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                wr(12'h008, 32'hFFFF_FFFF);
                wr(12'h004, 32'hFFFF_FFF0 | 32'(p));
                chk("R1 start", 64'(ch_run), 64'(p));
                wr(12'h004, 32'h0);
                chk("R1 zero start", 64'(ch_run), 64'(p));
                wr(12'h008, 32'(q));
                chk("R2 stop", 64'(ch_run), 64'(p & ~q & 15));
                wr(12'h008, 32'h0);
                rd(12'h00C, 4'h0, d);
                chk("R3 status", 64'(d), 64'(p & ~q & 15));
            end
        end
        wr(12'h004, 32'hF);
        rd(12'h00C, 4'h0, d); chk("R3 all run", 64'(d), 64'hF);

        // R4 R5 R6 flags
        rd(12'h01C, 4'h0, d);
        pulse(4'b0001);
        pulse(4'b1000);
        rd(12'h01C, 4'h0, d); chk("R5 flags read", 64'(d), 64'h9);
        rd(12'h01C, 4'h0, d); chk("R5 flags cleared", 64'(d), 64'h0);
        for (int m = 1; m < 16; m++) begin
            pulse(4'(m));
            rd(12'h01C, 4'h0, d); chk("R4 flags capture", 64'(d), 64'(m));
        end
        pulse(4'b0010);
        rd(12'h01C, 4'b0100, d); chk("R6 same-cycle read", 64'(d), 64'h2);
        rd(12'h01C, 4'h0, d); chk("R6 kept event", 64'(d), 64'h4);
        rd(12'h01C, 4'h0, d); chk("R6 then clear", 64'(d), 64'h0);

        // R7 R8 R10 window sweep
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 32; o += 4)
                wr(wa(c, o), pat(c, o));
        for (int c = 0; c < 4; c++)
            for (int o = 0; o < 32; o += 4) begin
                rd(wa(c, o), 4'h0, d);
                chk("R7 window readback", 64'(d), 64'(pat(c, o) & rmask(o)));
            end
        for (int c = 0; c < 4; c++) begin
            chk("R10 duty port", 64'(ch_duty[c*16 +: 16]), 64'(pat(c, 4) & 32'hFFFF));
            chk("R10 period port", 64'(ch_period[c*16 +: 16]), 64'(pat(c, 8) & 32'hFFFF));
            chk("R8 prescale port", 64'(ch_prescale[c*4 +: 4]), 64'(pat(c, 0) & 32'hF));
            chk("R8 invert port", 64'(ch_invert[c]), 64'((pat(c, 0) >> 9) & 1));
        end
        for (int m = 0; m < 8; m++) begin
            logic [31:0] mv;
            mv = {21'h1FFFFF, m[2], m[1], 5'h1F, 4'(m * 5)};
            wr(wa(3, 0), mv);
            rd(wa(3, 0), 4'h0, d);
            chk("R8 mode fields", 64'(d), 64'(mv & 32'h60F));
        end

        // R11 unmapped
        wr(12'h20C, 32'hFFFF_FFFF);
        wr(12'h280, 32'hFFFF_FFFF);
        wr(12'h205, 32'hFFFF_FFFF);
        wr(12'h7FC, 32'hFFFF_FFFF);
        rd(wa(0, 0), 4'h0, d); chk("R11 ignore mode", 64'(d), 64'(pat(0, 0) & 32'h60F));
        rd(wa(0, 4), 4'h0, d); chk("R11 ignore duty", 64'(d), 64'(pat(0, 4) & 32'hFFFF));
        rd(wa(0, 16), 4'h0, d); chk("R11 ignore stage", 64'(d), 64'(pat(0, 16) & 32'hFFFF));
        chk("R11 run kept", 64'(ch_run), 64'hF);
        begin
            logic [11:0] ua [8] = '{12'h000, 12'h010, 12'h014, 12'h018,
                                    12'h100, 12'h280, 12'h206, 12'h7FC};
            for (int i = 0; i < 8; i++) begin
                rd(ua[i], 4'h0, d); chk("R11 unmapped read", 64'(d), 64'h0);
            end
        end

        // R9 staging
        wr(wa(2, 0), 32'h0000_0003);
        wr(wa(2, 4), 32'h0000_0100);
        wr(wa(2, 16), 32'h0000_0222);
        rd(wa(2, 4), 4'h0, d); chk("R10 active before copy", 64'(d), 64'h100);
        rd(wa(2, 16), 4'h0, d); chk("R9 stage readback", 64'(d), 64'h222);
        pulse(4'b1011);
        chk("R9 other channels no copy", 64'(ch_duty[32 +: 16]), 64'h100);
        pulse(4'b0100);
        chk("R9 copy to duty port", 64'(ch_duty[32 +: 16]), 64'h222);
        rd(wa(2, 4), 4'h0, d); chk("R9 copy to duty read", 64'(d), 64'h222);
        wr(wa(2, 0), 32'h0000_0403);
        wr(wa(2, 16), 32'h0000_0333);
        pulse(4'b0010);
        chk("R9 period waits", 64'(ch_period[32 +: 16]), 64'(pat(2, 8) & 32'hFFFF));
        pulse(4'b0100);
        chk("R9 copy to period", 64'(ch_period[32 +: 16]), 64'h333);
        chk("R9 duty untouched", 64'(ch_duty[32 +: 16]), 64'h222);
        rd(12'h01C, 4'h0, d);

        // R12 idle read data
        @(negedge clk);
        chk("R12 idle rdata", 64'(bus_rdata), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule